// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic device. It holds a programmable AND plane and a fixed OR plane. Twelve dedicated inputs and ten feedback lines are each presented in true and complement form, which gives 44 array columns. A stored configuration of 132 rows, each 44 bits wide, chooses which columns take part in each product term. The product terms are split into three kinds. Each output has a group of sum terms, and the group sizes differ from output to output. Each output also has one enable term. Two further terms are shared by the whole device: one for reset and one for preset.

The array itself is purely combinational: its outputs depend only on the inputs and the stored rows. The configuration is loaded one row at a time through a word-wide port, addressed by row index, and only while `prog_en` is high. While programming is in progress every array output is held at 0. The macrocells and pin buffers that consume these outputs sit outside this block.

Top module: `sop_array`

## Requirements
- R1: After reset every stored cell reads 1 (erased). With `prog_en` low, every output is therefore 1: `sum_o`, `oe_o`, `areset_o` and `spreset_o`.
- R2: Column 2i carries signal i in true form and column 2i+1 carries it in complement form. Signals 0 to 11 are `in_i[11:0]` and signals 12 to 21 are `fb_i[9:0]`. A stored 0 connects a column and a stored 1 disconnects it. A product term is the AND of all the columns it connects.
- R3: A row with no connected column evaluates to 1.
- R4: A row that connects both the true and the complement column of the same signal evaluates to 0, whatever the inputs.
- R5: Outputs 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 sum rows. Output k's group starts at row 1 + Σ_{j<k}(size_j + 1). The group's first row is its enable row and the sum rows follow it. `sum_o[k]` is the OR of output k's sum rows only.
- R6: `oe_o[k]` equals the value of output k's enable row.
- R7: `areset_o` equals row 0 and `spreset_o` equals row 131 (the last row).
- R8: A write with `wr_en` high stores `wr_data` into row `wr_row` on the next rising clock edge, but only if `prog_en` is high. A write with `prog_en` low changes nothing.
- R9: While `prog_en` is high, all outputs are 0.
- R10: A write to a row index of 132 or above is dropped and leaves every stored row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset; erases every row |
| in_i | input | 12 | Dedicated array inputs |
| fb_i | input | 10 | Feedback lines from the output cells |
| prog_en | input | 1 | Programming mode; enables writes and forces outputs to 0 |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 8 | Row index of the write |
| wr_data | input | 44 | Row contents, one bit per column, 0 = connected |
| sum_o | output | 10 | OR of each output's sum rows |
| oe_o | output | 10 | Each output's enable term |
| areset_o | output | 1 | Global reset term |
| spreset_o | output | 1 | Global preset term |

## Verification
The hardest state to reach from the ports is a single row under test with all its neighbours silent. The erased array holds every term at 1, so any one row is masked by the rest of its group. The stimulus therefore first writes every row as a contradictory term, which reads 0. It then reopens chosen rows one at a time: a multi-column product, a group's last and first rows, one enable row, and the preset row. A bench model of all 132 rows predicts every output for each input pattern, followed by a burst of random inputs.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // number of sum rows owned by output k: rises by two toward the middle
  function automatic int unsigned grp_terms(int unsigned min_t, int unsigned n_out,
                                            int unsigned k);
    int unsigned d;
    d = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return min_t + 2 * d;
  endfunction

  // first row of output k's group (its enable row); row 0 is the reset term
  function automatic int unsigned grp_base(int unsigned min_t, int unsigned n_out,
                                           int unsigned k);
    int unsigned b;
    b = 1;
    for (int unsigned j = 0; j < k; j++) b += grp_terms(min_t, n_out, j) + 1;
    return b;
  endfunction

  // all groups plus reset and preset rows
  function automatic int unsigned row_total(int unsigned min_t, int unsigned n_out);
    return grp_base(min_t, n_out, n_out) + 1;
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int ROWS  = 132,
  parameter int COLS  = 44,
  parameter int ROW_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prog_en,
  input  logic                       wr_en,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic [COLS-1:0]            wr_data,
  output logic [ROWS-1:0][COLS-1:0]  cfg_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROWS-1:0][COLS-1:0] mem;
  logic row_in_range;
  logic wr_accept;

  assign row_in_range = (wr_row <= LAST_ROW);
  assign wr_accept    = prog_en & wr_en & row_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem <= '1;
    else if (wr_accept) mem[wr_row] <= wr_data;
  end

  assign cfg_o = mem;

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> mem[$past(wr_row)] == $past(wr_data));

  assert_locked_outside_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(mem));

  assert_range_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_row > LAST_ROW)) |=> $stable(mem));
endmodule

// File: rtl/sop_term.sv
module sop_term #(
  parameter int N_SIG = 22,
  localparam int COLS = 2 * N_SIG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] cols,
  input  logic [COLS-1:0] cfg_row,
  output logic            term
);
  logic [N_SIG-1:0] pair_hit;
  logic conflict;
  logic blank;

  assign term = &(cols | cfg_row);

  for (genvar i = 0; i < N_SIG; i++) begin : g_pair
    assign pair_hit[i] = ~cfg_row[2*i] & ~cfg_row[2*i+1];
  end
  assign conflict = |pair_hit;
  assign blank    = &cfg_row;

  assert_conflict_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !term);

  assert_blank_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> term);
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_pkg::*;
#(
  parameter int N_OUT = 10,
  parameter int MIN_T = 8,
  localparam int ROWS = int'(row_total(MIN_T, N_OUT))
) (
  input  logic [ROWS-1:0]  terms,
  output logic [N_OUT-1:0] sum_raw,
  output logic [N_OUT-1:0] oe_raw,
  output logic             ar_raw,
  output logic             sp_raw
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = int'(grp_base(MIN_T, N_OUT, k));
    localparam int CNT  = int'(grp_terms(MIN_T, N_OUT, k));
    assign oe_raw[k]  = terms[BASE];
    assign sum_raw[k] = |terms[BASE+1 +: CNT];
  end

  assign ar_raw = terms[0];
  assign sp_raw = terms[ROWS-1];
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N_IN  = 12,
  parameter int N_OUT = 10,
  parameter int MIN_T = 8,
  localparam int N_SIG = N_IN + N_OUT,
  localparam int COLS  = 2 * N_SIG,
  localparam int ROWS  = int'(row_total(MIN_T, N_OUT)),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    in_i,
  input  logic [N_OUT-1:0]   fb_i,
  input  logic               prog_en,
  input  logic               wr_en,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [COLS-1:0]    wr_data,
  output logic [N_OUT-1:0]   sum_o,
  output logic [N_OUT-1:0]   oe_o,
  output logic               areset_o,
  output logic               spreset_o
);
  logic [N_SIG-1:0]          sig;
  logic [COLS-1:0]           cols;
  logic [ROWS-1:0][COLS-1:0] cfg;
  logic [ROWS-1:0]           terms;
  logic [N_OUT-1:0]          sum_raw;
  logic [N_OUT-1:0]          oe_raw;
  logic                      ar_raw;
  logic                      sp_raw;

  assign sig = {fb_i, in_i};
  for (genvar i = 0; i < N_SIG; i++) begin : g_col
    assign cols[2*i]   = sig[i];
    assign cols[2*i+1] = ~sig[i];
  end

  sop_cfg_store #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_en (prog_en),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .cfg_o   (cfg)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    sop_term #(.N_SIG(N_SIG)) u_term (
      .clk     (clk),
      .rst_n   (rst_n),
      .cols    (cols),
      .cfg_row (cfg[r]),
      .term    (terms[r])
    );
  end

  sop_or_plane #(.N_OUT(N_OUT), .MIN_T(MIN_T)) u_or (
    .terms   (terms),
    .sum_raw (sum_raw),
    .oe_raw  (oe_raw),
    .ar_raw  (ar_raw),
    .sp_raw  (sp_raw)
  );

  assign sum_o     = prog_en ? '0   : sum_raw;
  assign oe_o      = prog_en ? '0   : oe_raw;
  assign areset_o  = prog_en ? 1'b0 : ar_raw;
  assign spreset_o = prog_en ? 1'b0 : sp_raw;

  assert_quiet_in_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (sum_o == '0 && oe_o == '0 && !areset_o && !spreset_o));
endmodule

// File: tb/sop_array_bench.sv
module sop_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 132;

  typedef struct {
    logic [9:0] s;
    logic [9:0] e;
    logic       a;
    logic       p;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] in_i = '0;
  logic [9:0]  fb_i = '0;
  logic        prog_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_row = '0;
  logic [43:0] wr_data = '0;
  logic [9:0]  sum_o;
  logic [9:0]  oe_o;
  logic        areset_o;
  logic        spreset_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t q[$];
  logic [43:0] mcfg[NROWS];
  int gsz[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_array u_sop_array (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .fb_i(fb_i),
    .prog_en(prog_en), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .sum_o(sum_o), .oe_o(oe_o), .areset_o(areset_o), .spreset_o(spreset_o)
  );

  // row of output k: j = -1 gives its enable row, j >= 0 its j-th sum row
  function automatic int row_of(int k, int j);
    int r = 1;
    for (int t = 0; t < k; t++) r += gsz[t] + 1;
    return r + j + 1;
  endfunction

  function automatic bit mterm(logic [43:0] row, logic [11:0] a, logic [9:0] f);
    for (int c = 0; c < 44; c++) begin
      if (row[c] == 1'b0) begin
        logic s;
        s = (c < 24) ? a[c/2] : f[(c-24)/2];
        if ((c % 2) == 1) s = ~s;
        if (s == 1'b0) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic exp_t predict(logic [11:0] a, logic [9:0] f, string tag);
    exp_t x;
    int r = 1;
    x.s = '0; x.e = '0;
    for (int k = 0; k < 10; k++) begin
      x.e[k] = mterm(mcfg[r], a, f);
      r++;
      for (int j = 0; j < gsz[k]; j++) begin
        if (mterm(mcfg[r], a, f)) x.s[k] = 1'b1;
        r++;
      end
    end
    x.a = mterm(mcfg[0], a, f);
    x.p = mterm(mcfg[NROWS-1], a, f);
    x.tag = tag;
    return x;
  endfunction

  task automatic apply(logic [11:0] a, logic [9:0] f, string tag);
    @(negedge clk);
    in_i = a; fb_i = f; prog_en = 1'b0; wr_en = 1'b0;
    q.push_back(predict(a, f, tag));
  endtask

  task automatic write_row(int row, logic [43:0] d, logic pe, string tag);
    exp_t z;
    @(negedge clk);
    prog_en = pe; wr_en = 1'b1; wr_row = 8'(row); wr_data = d;
    if (pe) begin
      z.s = '0; z.e = '0; z.a = 1'b0; z.p = 1'b0; z.tag = "R9";
      q.push_back(z);
    end else begin
      q.push_back(predict(in_i, fb_i, tag));
    end
    @(posedge clk);
    if (pe && row < NROWS) mcfg[row] = d;
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        checks++;
        if (sum_o !== x.s || oe_o !== x.e || areset_o !== x.a || spreset_o !== x.p) begin
          errors++;
          $display("FAIL %s: sum=%h oe=%h ar=%b sp=%b expected sum=%h oe=%h ar=%b sp=%b",
                   x.tag, sum_o, oe_o, areset_o, spreset_o, x.s, x.e, x.a, x.p);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NROWS; r++) mcfg[r] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: erased array reads all ones
    apply(12'h000, 10'h000, "R1");
    apply(12'hA5C, 10'h2F1, "R3");

    // R9: outputs silent while programming; R4: every row made contradictory
    for (int r = 0; r < NROWS; r++) write_row(r, 44'h0, 1'b1, "R9");
    apply(12'hFFF, 10'h3FF, "R4");
    apply(12'h000, 10'h000, "R4");

    // R7: reset row erased, preset row = in_i[0] true
    write_row(0, '1, 1'b1, "R9");
    write_row(NROWS-1, ~44'h1, 1'b1, "R9");
    apply(12'h000, 10'h000, "R7");
    apply(12'h001, 10'h000, "R7");

    // R2: output 0 first sum row = in0 & in1 & ~fb0
    write_row(row_of(0, 0), ~((44'h1 << 0) | (44'h1 << 2) | (44'h1 << 25)), 1'b1, "R9");
    apply(12'h003, 10'h000, "R2");
    apply(12'h003, 10'h001, "R2");
    apply(12'h001, 10'h000, "R2");

    // R5: output 3 last sum row = in2 & ~fb5; output 4 first sum row erased
    write_row(row_of(3, gsz[3]-1), ~((44'h1 << 4) | (44'h1 << 35)), 1'b1, "R9");
    apply(12'h004, 10'h000, "R5");
    apply(12'h004, 10'h020, "R5");
    write_row(row_of(4, 0), '1, 1'b1, "R9");
    apply(12'h000, 10'h3FF, "R5");

    // R6: output 9 enable row = ~in11
    write_row(row_of(9, -1), ~(44'h1 << 23), 1'b1, "R9");
    apply(12'h000, 10'h000, "R6");
    apply(12'h800, 10'h000, "R6");

    // R8: write without prog_en leaves reset row erased
    write_row(0, 44'h0, 1'b0, "R8");
    apply(12'h001, 10'h000, "R8");

    // R10: out-of-range row dropped
    write_row(200, '1, 1'b1, "R9");
    apply(12'h805, 10'h021, "R10");
    apply(12'h000, 10'h000, "R10");

    // mixed patterns against the full model
    for (int n = 0; n < 24; n++) apply(12'($urandom), 10'($urandom), "R2");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule